// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside the transmit path of an I2C master on a shared open-drain bus. It watches the synchronized SCL and SDA lines and compares them with the level the local master intends to put on SDA. On a wired-AND bus a master that drives low always overrides one that releases the line high. The local master therefore learns that another master has won when it intended a 1 and sees a 0 at an SCL rising edge.

On a loss the block raises a sticky lost flag and forces the master and transmit flags low, which puts the controller into slave-receiver mode. It also asks for SDA and SCL to be released so the winning master can carry on. The byte in flight is followed to its end. The block then pulses a one-cycle clear of the active-low transfer-pending flag and holds SCL low.

Software clears the lost flag, and with it the SCL hold, by reading or writing the data register or by writing the second control register. Every pin is plain control or status. There is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `i2c_arb_monitor`

## Requirements
- R1: Both bus lines pass through a two-stage synchronizer. A comparison happens on each synchronized SCL rising edge that is a data bit (bits 1 to 8 after a start) while `mst_in` and `trx_in` are both 1. If `sda_intent` differs from the synchronized SDA level, `al_flag` goes to 1 within four clock cycles of the SCL rise at the pin and stays at 1.
- R2: When the intended level matches the line at every data bit, `al_flag` stays 0.
- R3: While `al_flag` is 1, `mst_out` and `trx_out` are 0. While it is 0, they equal `mst_in` and `trx_in`.
- R4: `release_req` is 1 exactly while `al_flag` is 1, asking the local drivers to release SDA and SCL.
- R5: No comparison is made unless `mst_in` and `trx_in` are both 1.
- R6: The acknowledge slot (the ninth SCL rising edge after a start) is never compared.
- R7: When a whole byte is identical, comparison continues bit by bit into the next byte. A loss there sets `al_flag`.
- R8: After a loss, the SCL falling edge that ends the ninth bit of the current byte produces one single-cycle pulse on `pin_clr` and sets `scl_hold` to 1.
- R9: A 1 on `dbr_rd`, `dbr_wr` or `cr2_wr` clears `al_flag` and `scl_hold` on the next clock.
- R10: If a clear strobe coincides with a new mismatch, `al_flag` stays 1.
- R11: Reset leaves `al_flag`, `scl_hold`, `pin_clr` and `release_req` at 0. A start condition (SDA falling while SCL is high) resets the bit position to the start of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_intent | input | 1 | Level the local master intends on SDA (1 = released) |
| mst_in | input | 1 | Master mode flag from the controller |
| trx_in | input | 1 | Transmit mode flag from the controller |
| dbr_rd | input | 1 | Data register read strobe |
| dbr_wr | input | 1 | Data register write strobe |
| cr2_wr | input | 1 | Second control register write strobe |
| al_flag | output | 1 | Arbitration lost, sticky |
| mst_out | output | 1 | Master flag after arbitration |
| trx_out | output | 1 | Transmit flag after arbitration |
| release_req | output | 1 | Request to release SDA and SCL drivers |
| pin_clr | output | 1 | One-cycle clear of the active-low pending flag |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
A bit counter that has drifted or was not reset by a start shows within one byte. An acknowledge slot gets compared and `al_flag` rises where it should not, or a real data-bit loss is missed. A wrong flag register shows on `mst_out`, `trx_out` and `release_req` about four clocks after the deciding SCL edge. A bad byte-end detector shows about four clocks after the ninth SCL fall, as a missing or doubled `pin_clr` pulse or a missing `scl_hold`. The bench drives a second master and a slave acknowledge onto a modelled wired-AND line, so losses occur through the real bus behaviour.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  // Edge and condition events derived from the synchronized bus lines
  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '1;   // idle bus reads high
        else        stg[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q_out = stg[STAGES-1];

endmodule

// File: rtl/i2c_bit_framer.sv
module i2c_bit_framer
  import i2c_arb_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt,
  output logic     data_slot,
  output logic     byte_end
);

  localparam int FRAME = BITS + 1;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic             scl_d, sda_d;
  logic [CNT_W-1:0] bit_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_comb begin
    evt.rise  = scl_s & ~scl_d;
    evt.fall  = ~scl_s & scl_d;
    evt.start = scl_s & scl_d & sda_d & ~sda_s;
    evt.stop  = scl_s & scl_d & ~sda_d & sda_s;
  end

  // Position inside the nine-bit frame: counts SCL rises since start/byte end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     bit_pos <= '0;
    else if (evt.start || evt.stop)                 bit_pos <= '0;
    else if (evt.rise && bit_pos != CNT_W'(FRAME))  bit_pos <= bit_pos + 1'b1;
    else if (evt.fall && bit_pos == CNT_W'(FRAME))  bit_pos <= '0;
  end

  assign data_slot = evt.rise && (bit_pos < CNT_W'(BITS));
  assign byte_end  = evt.fall && (bit_pos == CNT_W'(FRAME));

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= CNT_W'(FRAME)) else $error("bit position out of range"); // R6

  AST_START_RESETS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> (bit_pos == '0)) else $error("start did not reset position"); // R11

endmodule

// File: rtl/i2c_arb_core.sv
module i2c_arb_core (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic sda_intent,
  input  logic mst_in,
  input  logic trx_in,
  input  logic data_slot,
  input  logic byte_end,
  input  logic clr_req,
  output logic al_q,
  output logic hold_q,
  output logic pin_q
);

  logic cmp_hit, lose_now, clear_now, end_fire;

  assign cmp_hit   = data_slot & mst_in & trx_in;
  assign lose_now  = cmp_hit & (sda_s != sda_intent);
  assign clear_now = clr_req & ~lose_now;          // a fresh loss wins over a clear
  assign end_fire  = al_q & byte_end & ~hold_q & ~clear_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q   <= 1'b0;
      hold_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      pin_q <= end_fire;
      if (lose_now)       al_q <= 1'b1;
      else if (clear_now) al_q <= 1'b0;
      if (clear_now)      hold_q <= 1'b0;
      else if (end_fire)  hold_q <= 1'b1;
    end
  end

  AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && sda_s != sda_intent) |=> al_q) else $error("mismatch missed"); // R1

  AST_MATCH_KEEPS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!al_q && data_slot && sda_s == sda_intent) |=> !al_q) else $error("loss on matching bit"); // R2

  AST_IDLE_MODE_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (!al_q && !(mst_in && trx_in)) |=> !al_q) else $error("loss outside master transmit"); // R5

  AST_NON_DATA_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (!al_q && !data_slot) |=> !al_q) else $error("loss outside a data bit"); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !lose_now) |=> (!al_q && !hold_q)) else $error("clear ignored"); // R9

  AST_LOSS_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && lose_now) |=> al_q) else $error("clear beat a new loss"); // R10

  AST_PIN_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q |-> hold_q) else $error("pending clear without hold"); // R8

  AST_PIN_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q |=> !pin_q) else $error("pending clear longer than one cycle"); // R8

  AST_HOLD_NEEDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> al_q) else $error("SCL hold without loss"); // R8

endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BITS        = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sda_intent,
  input  logic mst_in,
  input  logic trx_in,
  input  logic dbr_rd,
  input  logic dbr_wr,
  input  logic cr2_wr,
  output logic al_flag,
  output logic mst_out,
  output logic trx_out,
  output logic release_req,
  output logic pin_clr,
  output logic scl_hold
);

  logic [1:0] lines_s;
  bus_evt_t   evt;
  logic       data_slot, byte_end;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .q_out (lines_s)
  );

  i2c_bit_framer #(.BITS(BITS)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (lines_s[1]),
    .sda_s     (lines_s[0]),
    .evt       (evt),
    .data_slot (data_slot),
    .byte_end  (byte_end)
  );

  i2c_arb_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (lines_s[0]),
    .sda_intent (sda_intent),
    .mst_in     (mst_in),
    .trx_in     (trx_in),
    .data_slot  (data_slot),
    .byte_end   (byte_end),
    .clr_req    (dbr_rd | dbr_wr | cr2_wr),
    .al_q       (al_flag),
    .hold_q     (scl_hold),
    .pin_q      (pin_clr)
  );

  assign mst_out     = mst_in & ~al_flag;
  assign trx_out     = trx_in & ~al_flag;
  assign release_req = al_flag;

endmodule

// File: tb/sim_i2c_arb_monitor.sv
`timescale 1ns/1ps
module sim_i2c_arb_monitor;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_a = 1'b1, sda_a = 1'b1, b_bit = 1'b1;
  logic mst_in = 1'b1, trx_in = 1'b1;
  logic dbr_rd = 1'b0, dbr_wr = 1'b0, cr2_wr = 1'b0;
  logic al_flag, mst_out, trx_out, release_req, pin_clr, scl_hold;
  logic scl_line, sda_line;

  // Wired-AND bus: master A (plus slave ack) and local master B
  assign scl_line = scl_a & ~scl_hold;
  assign sda_line = sda_a & (b_bit | release_req);

  i2c_arb_monitor u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .sda_intent(b_bit), .mst_in(mst_in), .trx_in(trx_in),
    .dbr_rd(dbr_rd), .dbr_wr(dbr_wr), .cr2_wr(cr2_wr),
    .al_flag(al_flag), .mst_out(mst_out), .trx_out(trx_out),
    .release_req(release_req), .pin_clr(pin_clr), .scl_hold(scl_hold)
  );

  int n_chk = 0, n_err = 0, pin_cnt = 0, pin_exp = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rst_n && pin_clr) pin_cnt <= pin_cnt + 1;

  typedef struct packed {
    logic       mst;
    logic       trx;
    logic [7:0] a;
    logic [7:0] b;
    logic       lose;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{1'b1, 1'b1, 8'hA5, 8'hA5, 1'b0},
    '{1'b1, 1'b1, 8'h55, 8'hD5, 1'b1},
    '{1'b1, 1'b1, 8'hF0, 8'hF1, 1'b1},
    '{1'b0, 1'b1, 8'h00, 8'hFF, 1'b0},
    '{1'b1, 1'b0, 8'h00, 8'hFF, 1'b0},
    '{1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic a, input logic b, input logic clr_at_rise);
    @(negedge clk); sda_a = a; b_bit = b;
    repeat (4) @(negedge clk);
    scl_a = 1'b1;
    if (clr_at_rise) begin
      repeat (2) @(negedge clk); dbr_wr = 1'b1;
      @(negedge clk); dbr_wr = 1'b0;
      repeat (3) @(negedge clk);
    end else repeat (6) @(negedge clk);
    scl_a = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] a, input logic [7:0] b, input int clr_bit);
    for (int i = 7; i >= 0; i--) drive_bit(a[i], b[i], i == clr_bit);
    drive_bit(1'b0, 1'b1, 1'b0);   // slave ack low, B releases
  endtask

  task automatic bus_start;
    @(negedge clk); sda_a = 1'b1; b_bit = 1'b1;
    repeat (4) @(negedge clk); scl_a = 1'b1;
    repeat (6) @(negedge clk); sda_a = 1'b0; b_bit = 1'b0;
    repeat (6) @(negedge clk); scl_a = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_stop;
    @(negedge clk); sda_a = 1'b0; b_bit = 1'b0;
    repeat (4) @(negedge clk); scl_a = 1'b1;
    repeat (6) @(negedge clk); sda_a = 1'b1; b_bit = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: dbr_rd = 1'b1;
      1: dbr_wr = 1'b1;
      default: cr2_wr = 1'b1;
    endcase
    @(negedge clk); dbr_rd = 1'b0; dbr_wr = 1'b0; cr2_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 al after reset", al_flag, 0);
    chk("R11 hold after reset", scl_hold, 0);
    chk("R11 release after reset", release_req, 0);
    chk("R11 pin after reset", pin_clr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 mst follows input", mst_out, 1);

    // Vector table walk
    for (int v = 0; v < 6; v++) begin
      mst_in = VEC[v].mst; trx_in = VEC[v].trx;
      bus_start();
      send_byte(VEC[v].a, VEC[v].b, -1);
      repeat (2) @(negedge clk);
      if (VEC[v].lose) pin_exp++;
      chk($sformatf("R1 R2 R5 R6 vec%0d al", v), al_flag, VEC[v].lose);
      chk($sformatf("R3 vec%0d mst_out", v), mst_out, VEC[v].mst & ~VEC[v].lose);
      chk($sformatf("R3 vec%0d trx_out", v), trx_out, VEC[v].trx & ~VEC[v].lose);
      chk($sformatf("R4 vec%0d release", v), release_req, VEC[v].lose);
      chk($sformatf("R8 vec%0d hold", v), scl_hold, VEC[v].lose);
      chk($sformatf("R8 vec%0d pin count", v), pin_cnt, pin_exp);
      strobe(v % 3);
      chk($sformatf("R9 vec%0d al cleared", v), al_flag, 0);
      chk($sformatf("R9 vec%0d hold cleared", v), scl_hold, 0);
      bus_stop();
    end
    mst_in = 1'b1; trx_in = 1'b1;

    // R7: identical first byte, loss in second byte
    bus_start();
    send_byte(8'h3C, 8'h3C, -1);
    repeat (2) @(negedge clk);
    chk("R7 first byte no loss", al_flag, 0);
    chk("R6 ack slot not compared", pin_cnt, pin_exp);
    send_byte(8'h10, 8'h12, -1);
    repeat (2) @(negedge clk);
    pin_exp++;
    chk("R7 loss in second byte", al_flag, 1);
    chk("R8 single pending clear", pin_cnt, pin_exp);
    chk("R8 scl line held low", scl_line, 0);
    scl_a = 1'b1; repeat (6) @(negedge clk);
    chk("R8 hold keeps scl low", scl_line, 0);
    chk("R8 no second pulse", pin_cnt, pin_exp);
    scl_a = 1'b0;
    strobe(0);
    chk("R9 rd clears al", al_flag, 0);
    bus_stop();

    // R10: clear strobe coincides with the losing bit
    bus_start();
    send_byte(8'h00, 8'h80, 7);
    repeat (2) @(negedge clk);
    pin_exp++;
    chk("R10 loss beats clear", al_flag, 1);
    chk("R10 pending clear after loss", pin_cnt, pin_exp);
    strobe(0);
    chk("R9 clear after race", al_flag, 0);
    bus_stop();

    // R11: repeated start re-aligns the frame
    bus_start();
    drive_bit(1'b1, 1'b1, 1'b0);
    drive_bit(1'b0, 1'b0, 1'b0);
    drive_bit(1'b1, 1'b1, 1'b0);
    drive_bit(1'b1, 1'b1, 1'b0);
    drive_bit(1'b0, 1'b0, 1'b0);
    bus_start();
    send_byte(8'h5A, 8'h5A, -1);
    repeat (2) @(negedge clk);
    chk("R11 restart realigns ack slot", al_flag, 0);
    chk("R11 no pending clear", pin_cnt, pin_exp);
    bus_stop();

    done = 1'b1;
    report();
  end

endmodule